// File: doc/BRIEF.md
# ALU Status Flag Unit

This block is an 8-bit arithmetic/logic stage together with the status register that records the outcome of each operation. Every operation is described by four things: an operation code, two operands, a five-bit mask of the flags it may change, and a bit saying whether the result is written back into the status register. The block has five flags: negative, signed overflow, zero, nibble carry and carry. On each valid operation the flags in the mask are recomputed from the arithmetic, and the flags outside the mask keep their value.

The status register can also be the destination of an ordinary data write. A problem comes up when an instruction targets the status register and also changes flags, because the data write and the flag logic then both want the same bits. The flag logic takes priority over the data for the bits in the mask. Every other bit keeps its old value. The data only lands in full when the operation changes no flags. Subtraction is done as a two's-complement addition, so carry and nibble carry read 1 when no borrow occurred.

Top module: `alu_status_unit`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, `status` reads 0x00.
- R2: Bits 7 to 5 of `status` always read 0, even when a data write carries ones in those positions.
- R3: Op code 0 (add) gives `result = a + b`. Status bit 0 (carry) takes the carry out of bit 7. Bit 1 (nibble carry) takes the carry out of bit 3. Bit 3 (overflow) is set when the signed sum does not fit. Bit 4 (negative) takes result bit 7. Bit 2 (zero) is set when the result is 0.
- R4: Op code 1 (subtract) gives `result = a + ~b + 1`. Carry and nibble carry hold 1 when no borrow occurred and 0 when a borrow occurred. Overflow, negative and zero follow the same rules as in R3.
- R5: Op codes 2, 3 and 4 give AND, OR and XOR. Used with mask 0x14, they update only negative and zero.
- R6: Op code 5 rotates left through carry (`result = {a[6:0], C}`, and carry becomes a[7]). Op code 6 rotates right through carry (`result = {C, a[7:1]}`, and carry becomes a[0]).
- R7: Mask bit i (4 = negative, 3 = overflow, 2 = zero, 1 = nibble carry, 0 = carry) enables the update of status bit i. A flag whose mask bit is 0 keeps its value when `dest_status` is 0.
- R8: When `dest_status` is 1 and the mask is nonzero, the bits in the mask take their flag values and the bits outside the mask keep their old values. None of the result bits are written.
- R9: Op code 7 (clear) with mask 0x04 and `dest_status` = 1 sets zero and leaves the other four flags as they were.
- R10: With mask 0 and `dest_status` = 1, `status[4:0]` is loaded from `result[4:0]`. The results for this case are: op code 8 (move) gives b. Op code 9 (nibble swap) gives `{a[3:0], a[7:4]}`. Op code 10 (bit set) gives a with bit `b[2:0]` set. Op code 11 (bit clear) gives a with bit `b[2:0]` cleared.
- R11: While `op_valid` is low, `status` does not change.
- R12: `result` is a combinational function of `op`, `a`, `b` and the current carry flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An operation is issued this cycle |
| op | input | 4 | Operation code |
| a | input | 8 | First operand |
| b | input | 8 | Second operand, or bit index for bit set and bit clear |
| flag_mask | input | 5 | Flags this operation may update |
| dest_status | input | 1 | The operation writes its result into the status register |
| result | output | 8 | ALU result |
| status | output | 8 | Status register |

## Verification
The hardest case to reach is a flag-changing write that targets the status register while the register already holds a chosen mix of flags. This is the only case where leaving a bit untouched can be told apart from writing it. To get there, the bench first loads a known pattern into the register with a move that changes no flags. It then issues the operation under test, so each vector starts from a controlled status value. Vectors with opposite preload patterns catch the two failure directions: a result bit leaking through, and an unaffected flag being overwritten.

// File: rtl/alu_status_pkg.sv
`timescale 1ns/1ps
package alu_status_pkg;
   localparam int NUM_FLAGS = 5;
   localparam int FLG_C  = 0;
   localparam int FLG_DC = 1;
   localparam int FLG_Z  = 2;
   localparam int FLG_OV = 3;
   localparam int FLG_N  = 4;

   typedef enum logic [3:0] {
      OP_ADD  = 4'd0,
      OP_SUB  = 4'd1,
      OP_AND  = 4'd2,
      OP_OR   = 4'd3,
      OP_XOR  = 4'd4,
      OP_RLC  = 4'd5,
      OP_RRC  = 4'd6,
      OP_CLR  = 4'd7,
      OP_MOV  = 4'd8,
      OP_SWAP = 4'd9,
      OP_BSET = 4'd10,
      OP_BCLR = 4'd11
   } alu_op_e;

   // field order follows the status bit positions, 4 down to 0
   typedef struct packed {
      logic n;
      logic ov;
      logic z;
      logic dc;
      logic c;
   } flags_t;
endpackage

// File: rtl/alu_core.sv
`timescale 1ns/1ps
module alu_core
   import alu_status_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  alu_op_e           op,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic              carry_in,
   output logic [DATA_W-1:0] result,
   output logic              carry_out,
   output logic              half_carry,
   output logic              ovf
);
   localparam int NIB_W = DATA_W / 2;
   localparam int IDX_W = $clog2(DATA_W);
   localparam int MSB   = DATA_W - 1;

   logic              is_sub;
   logic [DATA_W-1:0] b_eff;
   logic [DATA_W:0]   sum_full;
   logic [NIB_W:0]    nib_sum;
   logic              carry_into_msb;
   logic [DATA_W-1:0] bit_onehot;

   // subtraction is addition of the inverted operand plus one
   assign is_sub   = (op == OP_SUB);
   assign b_eff    = is_sub ? ~b : b;
   assign sum_full = {1'b0, a} + {1'b0, b_eff} + (DATA_W+1)'(is_sub);
   assign nib_sum  = {1'b0, a[NIB_W-1:0]} + {1'b0, b_eff[NIB_W-1:0]}
                     + (NIB_W+1)'(is_sub);

   assign carry_into_msb = a[MSB] ^ b_eff[MSB] ^ sum_full[MSB];
   assign bit_onehot     = DATA_W'(1) << b[IDX_W-1:0];

   always_comb begin
      result     = a;
      carry_out  = carry_in;
      half_carry = nib_sum[NIB_W];
      ovf        = carry_into_msb ^ sum_full[DATA_W];
      unique case (op)
         OP_ADD, OP_SUB: begin
            result    = sum_full[DATA_W-1:0];
            carry_out = sum_full[DATA_W];
         end
         OP_AND:  result = a & b;
         OP_OR:   result = a | b;
         OP_XOR:  result = a ^ b;
         OP_RLC: begin
            result    = {a[MSB-1:0], carry_in};
            carry_out = a[MSB];
         end
         OP_RRC: begin
            result    = {carry_in, a[MSB:1]};
            carry_out = a[0];
         end
         OP_CLR:  result = '0;
         OP_MOV:  result = b;
         OP_SWAP: result = {a[NIB_W-1:0], a[MSB:NIB_W]};
         OP_BSET: result = a | bit_onehot;
         OP_BCLR: result = a & ~bit_onehot;
         default: result = a;
      endcase
   end
endmodule

// File: rtl/flag_gen.sv
`timescale 1ns/1ps
module flag_gen
   import alu_status_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] result,
   input  logic              carry_out,
   input  logic              half_carry,
   input  logic              ovf,
   output flags_t            flags
);
   always_comb begin
      flags.n  = result[DATA_W-1];
      flags.ov = ovf;
      flags.z  = ~|result;
      flags.dc = half_carry;
      flags.c  = carry_out;
   end
endmodule

// File: rtl/status_reg.sv
`timescale 1ns/1ps
module status_reg
   import alu_status_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 op_valid,
   input  logic                 dest_status,
   input  logic [NUM_FLAGS-1:0] flag_mask,
   input  flags_t               new_flags,
   input  logic [DATA_W-1:0]    wr_data,
   output logic [DATA_W-1:0]    status
);
   logic [NUM_FLAGS-1:0] flag_vec;
   logic                 data_wins;

   assign flag_vec  = new_flags;
   // data reaches the flag bits only when no flag is affected
   assign data_wins = dest_status && (flag_mask == '0);

   for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
      always_ff @(posedge clk) begin
         if (!rst_n)
            status[i] <= 1'b0;
         else if (op_valid) begin
            if (flag_mask[i])
               status[i] <= flag_vec[i];
            else if (data_wins)
               status[i] <= wr_data[i];
         end
      end
   end

   if (DATA_W > NUM_FLAGS) begin : g_unused
      assign status[DATA_W-1:NUM_FLAGS] = '0;
   end
endmodule

// File: rtl/alu_status_unit.sv
`timescale 1ns/1ps
module alu_status_unit
   import alu_status_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic [3:0]        op,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic [4:0]        flag_mask,
   input  logic              dest_status,
   output logic [DATA_W-1:0] result,
   output logic [DATA_W-1:0] status
);
   if (DATA_W < NUM_FLAGS || (DATA_W % 2) != 0) begin : g_bad_width
      $error("alu_status_unit: DATA_W must be even and at least NUM_FLAGS");
   end

   logic   c_out, h_out, v_out;
   flags_t flags;

   alu_core #(.DATA_W(DATA_W)) u_core (
      .op        (alu_op_e'(op)),
      .a         (a),
      .b         (b),
      .carry_in  (status[FLG_C]),
      .result    (result),
      .carry_out (c_out),
      .half_carry(h_out),
      .ovf       (v_out)
   );

   flag_gen #(.DATA_W(DATA_W)) u_flags (
      .result    (result),
      .carry_out (c_out),
      .half_carry(h_out),
      .ovf       (v_out),
      .flags     (flags)
   );

   status_reg #(.DATA_W(DATA_W)) u_stat (
      .clk        (clk),
      .rst_n      (rst_n),
      .op_valid   (op_valid),
      .dest_status(dest_status),
      .flag_mask  (flag_mask),
      .new_flags  (flags),
      .wr_data    (result),
      .status     (status)
   );
endmodule

// File: rtl/alu_status_chk.sv
`timescale 1ns/1ps
module alu_status_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              op_valid,
   input logic [4:0]        flag_mask,
   input logic              dest_status,
   input logic [DATA_W-1:0] result,
   input logic [DATA_W-1:0] status
);
   // R2
   a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      status[DATA_W-1:5] == '0);

   // R11
   a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |=> $stable(status));

   // R7
   a_r7_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && !dest_status) |=>
         (((status[4:0] ^ $past(status[4:0])) & ~$past(flag_mask)) == 5'd0));

   // R3
   a_r3_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && flag_mask[2]) |=> (status[2] == ($past(result) == '0)));

   // R3
   a_r3_neg_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && flag_mask[4]) |=> (status[4] == $past(result[DATA_W-1])));

   // R10
   a_r10_data_write: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && dest_status && flag_mask == 5'd0) |=>
         (status[4:0] == $past(result[4:0])));
endmodule

bind alu_status_unit alu_status_chk #(.DATA_W(DATA_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .op_valid   (op_valid),
   .flag_mask  (flag_mask),
   .dest_status(dest_status),
   .result     (result),
   .status     (status)
);

// File: tb/tb_alu_status_unit.sv
`timescale 1ns/1ps
module tb_alu_status_unit;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       op_valid = 1'b0;
   logic [3:0] op = '0;
   logic [7:0] a = '0;
   logic [7:0] b = '0;
   logic [4:0] flag_mask = '0;
   logic       dest_status = 1'b0;
   logic [7:0] result;
   logic [7:0] status;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #10 clk = ~clk;

   alu_status_unit dut (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op(op), .a(a), .b(b),
      .flag_mask(flag_mask), .dest_status(dest_status),
      .result(result), .status(status)
   );

   // {preload[4:0], op, a, b, mask, dest, exp_result, exp_status, req}
   localparam int NV = 24;
   localparam logic [50:0] TBL [NV] = '{
      {5'h00, 4'd0,  8'h7F, 8'h01, 5'h1F, 1'b0, 8'h80, 8'h1A, 4'd3},  // R3
      {5'h00, 4'd0,  8'hFF, 8'h01, 5'h1F, 1'b0, 8'h00, 8'h07, 4'd3},  // R3
      {5'h00, 4'd0,  8'h80, 8'h80, 5'h1F, 1'b0, 8'h00, 8'h0D, 4'd3},  // R3
      {5'h00, 4'd1,  8'h05, 8'h03, 5'h1F, 1'b0, 8'h02, 8'h03, 4'd4},  // R4
      {5'h00, 4'd1,  8'h03, 8'h05, 5'h1F, 1'b0, 8'hFE, 8'h10, 4'd4},  // R4
      {5'h00, 4'd1,  8'h80, 8'h01, 5'h1F, 1'b0, 8'h7F, 8'h09, 4'd4},  // R4
      {5'h00, 4'd1,  8'h10, 8'h01, 5'h1F, 1'b0, 8'h0F, 8'h01, 4'd4},  // R4
      {5'h0B, 4'd2,  8'hF0, 8'h0F, 5'h14, 1'b0, 8'h00, 8'h0F, 4'd5},  // R5
      {5'h07, 4'd4,  8'h80, 8'h00, 5'h14, 1'b0, 8'h80, 8'h13, 4'd5},  // R5
      {5'h00, 4'd3,  8'h00, 8'h00, 5'h14, 1'b0, 8'h00, 8'h04, 4'd5},  // R5
      {5'h00, 4'd5,  8'h81, 8'h00, 5'h15, 1'b0, 8'h02, 8'h01, 4'd6},  // R6
      {5'h01, 4'd5,  8'h40, 8'h00, 5'h15, 1'b0, 8'h81, 8'h10, 4'd6},  // R6
      {5'h00, 4'd6,  8'h01, 8'h00, 5'h15, 1'b0, 8'h00, 8'h05, 4'd6},  // R6
      {5'h01, 4'd6,  8'h02, 8'h00, 5'h15, 1'b0, 8'h81, 8'h10, 4'd6},  // R6
      {5'h1E, 4'd0,  8'hFF, 8'h01, 5'h01, 1'b0, 8'h00, 8'h1F, 4'd7},  // R7
      {5'h0A, 4'd0,  8'h01, 8'h01, 5'h00, 1'b0, 8'h02, 8'h0A, 4'd7},  // R7
      {5'h15, 4'd8,  8'h00, 8'h33, 5'h00, 1'b0, 8'h33, 8'h15, 4'd7},  // R7
      {5'h1B, 4'd7,  8'h5A, 8'h00, 5'h04, 1'b1, 8'h00, 8'h1F, 4'd9},  // R9
      {5'h00, 4'd7,  8'h5A, 8'h00, 5'h04, 1'b1, 8'h00, 8'h04, 4'd9},  // R9
      {5'h00, 4'd0,  8'h0F, 8'h01, 5'h1F, 1'b1, 8'h10, 8'h02, 4'd8},  // R8
      {5'h0B, 4'd2,  8'hFF, 8'h07, 5'h14, 1'b1, 8'h07, 8'h0B, 4'd8},  // R8
      {5'h00, 4'd9,  8'h5A, 8'h00, 5'h00, 1'b1, 8'hA5, 8'h05, 4'd10}, // R10
      {5'h00, 4'd10, 8'h00, 8'h03, 5'h00, 1'b1, 8'h08, 8'h08, 4'd10}, // R10
      {5'h1F, 4'd11, 8'hFF, 8'h00, 5'h00, 1'b1, 8'hFE, 8'h1E, 4'd10}  // R10
   };

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // drive one operation; the result is sampled before the rising edge,
   // and the status is sampled at the following falling edge
   task automatic run_op(input logic [3:0] o, input logic [7:0] aa, input logic [7:0] bb,
                         input logic [4:0] m, input logic d, output logic [7:0] res);
      @(negedge clk);
      op = o; a = aa; b = bb; flag_mask = m; dest_status = d; op_valid = 1'b1;
      #5 res = result;
      @(negedge clk);
      op_valid = 1'b0;
   endtask

   initial begin
      #(20 * 100000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [7:0] r;
      repeat (3) @(negedge clk);
      check("R1 reset", status, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after release", status, 8'h00);

      for (int i = 0; i < NV; i++) begin
         logic [50:0] v;
         v = TBL[i];
         run_op(4'd8, 8'h00, {3'b000, v[50:46]}, 5'h00, 1'b1, r);  // preload
         run_op(v[45:42], v[41:34], v[33:26], v[25:21], v[20], r);
         check($sformatf("R12 vec%0d result (R%0d)", i, v[3:0]), r, v[19:12]);
         check($sformatf("R%0d vec%0d status", v[3:0], i), status, v[11:4]);
      end

      // R2: upper bits ignore a data write
      run_op(4'd8, 8'h00, 8'hE0, 5'h00, 1'b1, r);
      check("R2 upper bits", status, 8'h00);
      run_op(4'd8, 8'h00, 8'hFF, 5'h00, 1'b1, r);
      check("R2 full ones", status, 8'h1F);

      // R11: no update while op_valid is low
      @(negedge clk);
      op = 4'd8; b = 8'h00; flag_mask = 5'h00; dest_status = 1'b1; op_valid = 1'b0;
      @(negedge clk);
      check("R11 idle hold", status, 8'h1F);

      // R12: the result follows the carry flag combinationally
      @(negedge clk);
      op = 4'd5; a = 8'h00; op_valid = 1'b0;
      #1 check("R12 rotate uses carry", result, 8'h01);

      // R1: reset in mid-run clears the flags
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 mid-run reset", status, 8'h00);
      rst_n = 1'b1;

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule